// File: doc/BRIEF.md
# Dual-Port Blocking Memory Forwarder

This block sits between a processor and its memory. Two request/response ports face the processor. One carries instruction fetches and the other carries data accesses. A single request/response port faces memory. The forwarder takes one request at a time from either processor-side port and passes it unchanged to memory. It then waits for the memory reply and returns that reply on a processor-side port. The fetch flag that travelled with the original request selects that port. No second request is taken while one is outstanding.

Every channel uses a valid/ready handshake with explicit retry pulses instead of back-pressure by holding valid. A sender presents an item for one cycle. If the receiver does not accept it in that cycle, the sender drops valid and keeps the item. It presents the item again one cycle after the receiver pulses retry.

The same rule applies towards the processor. A requester that the forwarder turns away is owed a retry. The forwarder pays that retry in a cycle in which a response is handed over, provided the requester's own response buffer is then empty or is being emptied in that same cycle.

The memory side is run by a four-state machine:
- MEM_IDLE goes to MEM_SEND when a request is granted.
- MEM_SEND goes to MEM_WAIT if memory accepts the request, and to MEM_HOLD if memory refuses it.
- MEM_HOLD goes back to MEM_SEND on a memory retry pulse.
- MEM_WAIT goes to MEM_IDLE when the memory response is taken.

Each processor-side port has a three-state response machine:
- RSP_EMPTY goes to RSP_SEND when the port's response buffer is filled.
- RSP_SEND goes to RSP_EMPTY if the processor accepts the response, and to RSP_HOLD if it refuses.
- RSP_HOLD goes back to RSP_SEND on the processor's response-retry pulse.

Top module: `dual_port_mem_forwarder`

## Requirements
- R1: With the forwarder idle (memory machine in MEM_IDLE), a processor-side port raises its request ready if the response buffer of the request's destination port is empty. The destination is the instruction port when the request's fetch flag is 1 and the data port when it is 0. An accepted request appears on the memory request outputs in the next cycle, with address, write flag, fetch flag, size and write data unchanged.
- R2: From the cycle after a request is accepted until the memory response has been taken, both request ready outputs stay low and no second request is granted.
- R3: When both processor-side ports present a request in the same cycle, only the instruction port can be accepted. The data port sees ready low in that cycle.
- R4: The cycle after the memory response is taken, the response appears on the instruction port if the stored fetch flag is 1, and on the data port otherwise. It carries the memory read data and the fetch flag, and the other port's response valid stays low.
- R5: If memory does not raise ready while the memory request is valid, the request valid goes low in the next cycle and stays low until a memory retry pulse. One cycle after that pulse the same request is presented again.
- R6: Memory response ready is high only while a memory response is awaited. It is low in the cycle after the response is taken.
- R7: If the processor does not accept a response while it is valid, the response valid goes low in the next cycle. The response is kept, and it is presented again with the same data one cycle after that port's response-retry pulse.
- R8: A request presented while ready is low makes that port owe a retry. The port pulses its retry output only in a cycle in which some port hands over a response (valid and ready both high), and only if its own response buffer is empty or is being handed over in that cycle. The owed retry is then cleared.
- R9: A request whose destination port still holds an undelivered response is refused even while memory is idle. A request to the other destination is still accepted.
- R10: A synchronous active-high reset empties the request and response buffers, clears the busy condition and clears both owed retries. All valid and retry outputs are then low and request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ireq_valid | input | 1 | Instruction-side request valid |
| ireq_ready | output | 1 | Instruction-side request accepted this cycle |
| ireq_addr | input | AW | Instruction-side request address |
| ireq_write | input | 1 | Instruction-side write flag |
| ireq_fetch | input | 1 | Instruction-side fetch flag (1 = fetch) |
| ireq_size | input | SW | Instruction-side access size in bytes |
| ireq_wdata | input | DW | Instruction-side write data |
| ireq_retry | output | 1 | Retry pulse to the instruction requester |
| irsp_valid | output | 1 | Instruction-side response valid |
| irsp_ready | input | 1 | Instruction-side response accepted |
| irsp_data | output | DW | Instruction-side response data |
| irsp_fetch | output | 1 | Fetch flag of the instruction-side response |
| irsp_retry | input | 1 | Response retry pulse from the instruction side |
| dreq_valid | input | 1 | Data-side request valid |
| dreq_ready | output | 1 | Data-side request accepted this cycle |
| dreq_addr | input | AW | Data-side request address |
| dreq_write | input | 1 | Data-side write flag |
| dreq_fetch | input | 1 | Data-side fetch flag |
| dreq_size | input | SW | Data-side access size in bytes |
| dreq_wdata | input | DW | Data-side write data |
| dreq_retry | output | 1 | Retry pulse to the data requester |
| drsp_valid | output | 1 | Data-side response valid |
| drsp_ready | input | 1 | Data-side response accepted |
| drsp_data | output | DW | Data-side response data |
| drsp_fetch | output | 1 | Fetch flag of the data-side response |
| drsp_retry | input | 1 | Response retry pulse from the data side |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request this cycle |
| mreq_addr | output | AW | Memory request address |
| mreq_write | output | 1 | Memory request write flag |
| mreq_fetch | output | 1 | Memory request fetch flag |
| mreq_size | output | SW | Memory request size |
| mreq_wdata | output | DW | Memory request write data |
| mreq_retry | input | 1 | Retry pulse from memory |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Forwarder takes the memory response |
| mrsp_data | input | DW | Memory response data |

## Verification
The timing of each result is fixed by the registers on its path:
- A granted request reaches the memory outputs one cycle after the accepting edge.
- A taken memory response reaches a processor port one cycle after that edge.
- A retry pulse on either side brings back a held item one cycle later.
- Ready and retry towards the requesters are combinational in the cycle they apply to.

The bench drives and samples only at the falling edge, a short settle time after driving. It checks registered results at the first falling edge after the expected rising edge. It checks ready and retry in the same half-cycle as the stimulus that causes them. The sweep covers every mix of active ports, fetch flags, memory refusal and processor refusal. Expected routing, payload and read data (address times three plus seven) are worked out from the loop variables.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int NPORT     = 2;
    localparam int PORT_INST = 0;
    localparam int PORT_DATA = 1;

    typedef enum logic [1:0] {
        MEM_IDLE,
        MEM_SEND,
        MEM_HOLD,
        MEM_WAIT
    } mem_state_e;

    typedef enum logic [1:0] {
        RSP_EMPTY,
        RSP_SEND,
        RSP_HOLD
    } rsp_state_e;

    // Destination port of an item, chosen by its fetch flag
    function automatic int dest_of(input logic fetch);
        return fetch ? PORT_INST : PORT_DATA;
    endfunction

endpackage

// File: rtl/fwd_arbiter.sv
module fwd_arbiter
    import fwd_pkg::*;
#(
    parameter int NP = NPORT
) (
    input  logic          busy,
    input  logic [NP-1:0] req_valid,
    input  logic [NP-1:0] req_fetch,
    input  logic [NP-1:0] rsp_free,
    output logic [NP-1:0] req_ready,
    output logic [NP-1:0] grant,
    output logic [NP-1:0] refuse
);

    // Lower index means higher priority
    always_comb begin
        logic higher;
        higher = 1'b0;
        for (int p = 0; p < NP; p++) begin
            req_ready[p] = !busy && rsp_free[dest_of(req_fetch[p])] && !higher;
            grant[p]     = req_valid[p] && req_ready[p];
            refuse[p]    = req_valid[p] && !req_ready[p];
            higher       = higher | req_valid[p];
        end
    end

endmodule

// File: rtl/fwd_mem_ctrl.sv
module fwd_mem_ctrl
    import fwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_write,
    input  logic          ld_fetch,
    input  logic [SW-1:0] ld_size,
    input  logic [DW-1:0] ld_wdata,
    output logic          busy,
    output logic          mreq_valid,
    input  logic          mreq_ready,
    output logic [AW-1:0] mreq_addr,
    output logic          mreq_write,
    output logic          mreq_fetch,
    output logic [SW-1:0] mreq_size,
    output logic [DW-1:0] mreq_wdata,
    input  logic          mreq_retry,
    input  logic          mrsp_valid,
    output logic          mrsp_ready,
    input  logic [DW-1:0] mrsp_data,
    output logic          fill_valid,
    output logic          fill_fetch,
    output logic [DW-1:0] fill_data
);

    mem_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          write_q, fetch_q;
    logic [SW-1:0] size_q;
    logic [DW-1:0] wdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MEM_IDLE: if (load)       state_d = MEM_SEND;
            MEM_SEND: state_d = mreq_ready ? MEM_WAIT : MEM_HOLD;
            MEM_HOLD: if (mreq_retry) state_d = MEM_SEND;
            MEM_WAIT: if (mrsp_valid) state_d = MEM_IDLE;
            default:  state_d = MEM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MEM_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            fetch_q <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
        end else if (load && state_q == MEM_IDLE) begin
            addr_q  <= ld_addr;
            write_q <= ld_write;
            fetch_q <= ld_fetch;
            size_q  <= ld_size;
            wdata_q <= ld_wdata;
        end
    end

    always_comb begin
        busy       = (state_q != MEM_IDLE);
        mreq_valid = (state_q == MEM_SEND);
        mrsp_ready = (state_q == MEM_WAIT);
        fill_valid = (state_q == MEM_WAIT) && mrsp_valid;
        fill_fetch = fetch_q;
        fill_data  = mrsp_data;
        mreq_addr  = addr_q;
        mreq_write = write_q;
        mreq_fetch = fetch_q;
        mreq_size  = size_q;
        mreq_wdata = wdata_q;
    end

    assert_grant_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        load |-> state_q == MEM_IDLE);
    assert_refused_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> !mreq_valid);
    assert_refused_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> $stable(mreq_addr) && $stable(mreq_wdata));
    assert_rsp_frees_R6: assert property (@(posedge clk) disable iff (rst)
        (mrsp_valid && mrsp_ready) |=> !busy && !mrsp_ready);

endmodule

// File: rtl/fwd_rsp_port.sv
module fwd_rsp_port
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill,
    input  logic          fill_fetch,
    input  logic [DW-1:0] fill_data,
    input  logic          refuse,
    input  logic          wake,
    input  logic          rsp_ready,
    input  logic          rsp_retry,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fetch,
    output logic          req_retry,
    output logic          free,
    output logic          delivered
);

    rsp_state_e    state_q, state_d;
    logic [DW-1:0] data_q;
    logic          fetch_q;
    logic          owed_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_EMPTY: if (fill)      state_d = RSP_SEND;
            RSP_SEND:  state_d = rsp_ready ? RSP_EMPTY : RSP_HOLD;
            RSP_HOLD:  if (rsp_retry) state_d = RSP_SEND;
            default:   state_d = RSP_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            fetch_q <= 1'b0;
            owed_q  <= 1'b0;
        end else begin
            if (fill && state_q == RSP_EMPTY) begin
                data_q  <= fill_data;
                fetch_q <= fill_fetch;
            end
            owed_q <= (owed_q && !req_retry) || refuse;
        end
    end

    always_comb begin
        rsp_valid = (state_q == RSP_SEND);
        free      = (state_q == RSP_EMPTY);
        delivered = (state_q == RSP_SEND) && rsp_ready;
        rsp_data  = data_q;
        rsp_fetch = fetch_q;
        req_retry = wake && owed_q && (free || delivered);
    end

    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
        fill |-> state_q == RSP_EMPTY);
    assert_refused_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> !rsp_valid && $stable(rsp_data));
    assert_refuse_owes_R8: assert property (@(posedge clk) disable iff (rst)
        refuse |=> owed_q);
    assert_retry_on_wake_R8: assert property (@(posedge clk) disable iff (rst)
        req_retry |-> wake);

endmodule

// File: rtl/dual_port_mem_forwarder.sv
module dual_port_mem_forwarder
    import fwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ireq_valid,
    output logic          ireq_ready,
    input  logic [AW-1:0] ireq_addr,
    input  logic          ireq_write,
    input  logic          ireq_fetch,
    input  logic [SW-1:0] ireq_size,
    input  logic [DW-1:0] ireq_wdata,
    output logic          ireq_retry,
    output logic          irsp_valid,
    input  logic          irsp_ready,
    output logic [DW-1:0] irsp_data,
    output logic          irsp_fetch,
    input  logic          irsp_retry,
    input  logic          dreq_valid,
    output logic          dreq_ready,
    input  logic [AW-1:0] dreq_addr,
    input  logic          dreq_write,
    input  logic          dreq_fetch,
    input  logic [SW-1:0] dreq_size,
    input  logic [DW-1:0] dreq_wdata,
    output logic          dreq_retry,
    output logic          drsp_valid,
    input  logic          drsp_ready,
    output logic [DW-1:0] drsp_data,
    output logic          drsp_fetch,
    input  logic          drsp_retry,
    output logic          mreq_valid,
    input  logic          mreq_ready,
    output logic [AW-1:0] mreq_addr,
    output logic          mreq_write,
    output logic          mreq_fetch,
    output logic [SW-1:0] mreq_size,
    output logic [DW-1:0] mreq_wdata,
    input  logic          mreq_retry,
    input  logic          mrsp_valid,
    output logic          mrsp_ready,
    input  logic [DW-1:0] mrsp_data
);

    logic [NPORT-1:0] req_valid, req_fetch, req_write, req_ready, grant, refuse;
    logic [AW-1:0]    req_addr  [NPORT];
    logic [SW-1:0]    req_size  [NPORT];
    logic [DW-1:0]    req_wdata [NPORT];

    logic [NPORT-1:0] p_rsp_ready, p_rsp_retry, p_rsp_valid, p_rsp_fetch;
    logic [NPORT-1:0] p_req_retry, p_free, p_delivered, p_fill;
    logic [DW-1:0]    p_rsp_data [NPORT];

    logic          busy, wake, fill_valid, fill_fetch;
    logic [DW-1:0] fill_data;
    logic          ld_write, ld_fetch;
    logic [AW-1:0] ld_addr;
    logic [SW-1:0] ld_size;
    logic [DW-1:0] ld_wdata;

    always_comb begin
        req_valid[PORT_INST] = ireq_valid;
        req_fetch[PORT_INST] = ireq_fetch;
        req_write[PORT_INST] = ireq_write;
        req_addr[PORT_INST]  = ireq_addr;
        req_size[PORT_INST]  = ireq_size;
        req_wdata[PORT_INST] = ireq_wdata;
        req_valid[PORT_DATA] = dreq_valid;
        req_fetch[PORT_DATA] = dreq_fetch;
        req_write[PORT_DATA] = dreq_write;
        req_addr[PORT_DATA]  = dreq_addr;
        req_size[PORT_DATA]  = dreq_size;
        req_wdata[PORT_DATA] = dreq_wdata;
        p_rsp_ready[PORT_INST] = irsp_ready;
        p_rsp_retry[PORT_INST] = irsp_retry;
        p_rsp_ready[PORT_DATA] = drsp_ready;
        p_rsp_retry[PORT_DATA] = drsp_retry;
    end

    fwd_arbiter #(.NP(NPORT)) arb_i (
        .busy      (busy),
        .req_valid (req_valid),
        .req_fetch (req_fetch),
        .rsp_free  (p_free),
        .req_ready (req_ready),
        .grant     (grant),
        .refuse    (refuse)
    );

    // Payload of the granted port
    always_comb begin
        ld_addr  = '0;
        ld_write = 1'b0;
        ld_fetch = 1'b0;
        ld_size  = '0;
        ld_wdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (grant[p]) begin
                ld_addr  = req_addr[p];
                ld_write = req_write[p];
                ld_fetch = req_fetch[p];
                ld_size  = req_size[p];
                ld_wdata = req_wdata[p];
            end
        end
    end

    fwd_mem_ctrl #(.AW(AW), .DW(DW), .SW(SW)) mem_i (
        .clk        (clk),
        .rst        (rst),
        .load       (|grant),
        .ld_addr    (ld_addr),
        .ld_write   (ld_write),
        .ld_fetch   (ld_fetch),
        .ld_size    (ld_size),
        .ld_wdata   (ld_wdata),
        .busy       (busy),
        .mreq_valid (mreq_valid),
        .mreq_ready (mreq_ready),
        .mreq_addr  (mreq_addr),
        .mreq_write (mreq_write),
        .mreq_fetch (mreq_fetch),
        .mreq_size  (mreq_size),
        .mreq_wdata (mreq_wdata),
        .mreq_retry (mreq_retry),
        .mrsp_valid (mrsp_valid),
        .mrsp_ready (mrsp_ready),
        .mrsp_data  (mrsp_data),
        .fill_valid (fill_valid),
        .fill_fetch (fill_fetch),
        .fill_data  (fill_data)
    );

    assign wake = |p_delivered;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign p_fill[p] = fill_valid && (dest_of(fill_fetch) == p);

        fwd_rsp_port #(.DW(DW)) port_i (
            .clk        (clk),
            .rst        (rst),
            .fill       (p_fill[p]),
            .fill_fetch (fill_fetch),
            .fill_data  (fill_data),
            .refuse     (refuse[p]),
            .wake       (wake),
            .rsp_ready  (p_rsp_ready[p]),
            .rsp_retry  (p_rsp_retry[p]),
            .rsp_valid  (p_rsp_valid[p]),
            .rsp_data   (p_rsp_data[p]),
            .rsp_fetch  (p_rsp_fetch[p]),
            .req_retry  (p_req_retry[p]),
            .free       (p_free[p]),
            .delivered  (p_delivered[p])
        );
    end

    always_comb begin
        ireq_ready = req_ready[PORT_INST];
        dreq_ready = req_ready[PORT_DATA];
        ireq_retry = p_req_retry[PORT_INST];
        dreq_retry = p_req_retry[PORT_DATA];
        irsp_valid = p_rsp_valid[PORT_INST];
        irsp_data  = p_rsp_data[PORT_INST];
        irsp_fetch = p_rsp_fetch[PORT_INST];
        drsp_valid = p_rsp_valid[PORT_DATA];
        drsp_data  = p_rsp_data[PORT_DATA];
        drsp_fetch = p_rsp_fetch[PORT_DATA];
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ireq_valid && ireq_ready, dreq_valid && dreq_ready}));
    assert_inst_priority_R3: assert property (@(posedge clk) disable iff (rst)
        (ireq_valid && dreq_valid) |-> !dreq_ready);
    assert_one_response_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irsp_valid, drsp_valid}));
    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> !ireq_ready && !dreq_ready);

endmodule

// File: tb/dual_port_mem_forwarder_tb.sv
module dual_port_mem_forwarder_tb_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic ireq_valid = 0, ireq_write = 0, ireq_fetch = 0;
    logic [AW-1:0] ireq_addr = '0;
    logic [SW-1:0] ireq_size = '0;
    logic [DW-1:0] ireq_wdata = '0;
    logic dreq_valid = 0, dreq_write = 0, dreq_fetch = 0;
    logic [AW-1:0] dreq_addr = '0;
    logic [SW-1:0] dreq_size = '0;
    logic [DW-1:0] dreq_wdata = '0;
    logic irsp_ready = 0, irsp_retry = 0, drsp_ready = 0, drsp_retry = 0;
    logic mreq_ready = 0, mreq_retry = 0, mrsp_valid = 0;
    logic [DW-1:0] mrsp_data = '0;

    logic ireq_ready, ireq_retry, irsp_valid, irsp_fetch;
    logic dreq_ready, dreq_retry, drsp_valid, drsp_fetch;
    logic [DW-1:0] irsp_data, drsp_data, mreq_wdata;
    logic mreq_valid, mreq_write, mreq_fetch, mrsp_ready;
    logic [AW-1:0] mreq_addr;
    logic [SW-1:0] mreq_size;

    int n_checks = 0;
    int n_fail   = 0;

    dual_port_mem_forwarder #(.AW(AW), .DW(DW), .SW(SW)) dut_i (
        .clk(clk), .rst(rst),
        .ireq_valid(ireq_valid), .ireq_ready(ireq_ready), .ireq_addr(ireq_addr),
        .ireq_write(ireq_write), .ireq_fetch(ireq_fetch), .ireq_size(ireq_size),
        .ireq_wdata(ireq_wdata), .ireq_retry(ireq_retry),
        .irsp_valid(irsp_valid), .irsp_ready(irsp_ready), .irsp_data(irsp_data),
        .irsp_fetch(irsp_fetch), .irsp_retry(irsp_retry),
        .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr),
        .dreq_write(dreq_write), .dreq_fetch(dreq_fetch), .dreq_size(dreq_size),
        .dreq_wdata(dreq_wdata), .dreq_retry(dreq_retry),
        .drsp_valid(drsp_valid), .drsp_ready(drsp_ready), .drsp_data(drsp_data),
        .drsp_fetch(drsp_fetch), .drsp_retry(drsp_retry),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_write(mreq_write), .mreq_fetch(mreq_fetch), .mreq_size(mreq_size),
        .mreq_wdata(mreq_wdata), .mreq_retry(mreq_retry),
        .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
        return a * 3 + 7;
    endfunction

    // Move the memory side from presentation to response (R5, R6)
    task automatic mem_side(input logic [AW-1:0] wa, input bit mref);
        if (mref) begin
            mreq_ready = 0;
            @(negedge clk); #1;
            chk(mreq_valid == 0, "R5 drop", mreq_valid, 0);
            @(negedge clk); mreq_retry = 1; #1;
            chk(mreq_valid == 0, "R5 wait", mreq_valid, 0);
            @(negedge clk); mreq_retry = 0; #1;
            chk(mreq_valid == 1 && mreq_addr == wa, "R5 resend", mreq_addr, wa);
        end
        mreq_ready = 1;
        @(negedge clk); mreq_ready = 0; #1;
        chk(mrsp_ready == 1, "R6 await", mrsp_ready, 1);
        mrsp_valid = 1; mrsp_data = mem_model(wa);
        @(negedge clk); mrsp_valid = 0; #1;
        chk(mrsp_ready == 0, "R6 done", mrsp_ready, 0);
    endtask

    task automatic run_txn(input int idx, input bit ui, input bit ud, input bit fi,
                           input bit fd, input bit mref, input bit rref);
        logic [AW-1:0] ai, ad, wa;
        logic [SW-1:0] sz;
        bit wf, owed_d, dst_i;
        logic [DW-1:0] ed;
        ai = 32'h1000 + idx * 16;
        ad = 32'h2000 + idx * 16;
        sz = SW'(idx % 8 + 1);
        @(negedge clk);
        ireq_valid = ui; ireq_addr = ai; ireq_fetch = fi; ireq_write = idx[0];
        ireq_size = sz; ireq_wdata = ~ai;
        dreq_valid = ud; dreq_addr = ad; dreq_fetch = fd; dreq_write = !idx[0];
        dreq_size = sz; dreq_wdata = ~ad;
        #1;
        if (ui) chk(ireq_ready == 1, "R1 inst accept", ireq_ready, 1);
        if (ud) chk(dreq_ready == !ui, "R3 data arb", dreq_ready, !ui);
        wa = ui ? ai : ad;
        wf = ui ? fi : fd;
        owed_d = ui && ud;
        @(negedge clk); ireq_valid = 0; dreq_valid = 0; #1;
        chk(mreq_valid && mreq_addr == wa && mreq_fetch == wf && mreq_size == sz,
            "R1 forward", mreq_addr, wa);
        chk(mreq_write == (ui ? idx[0] : !idx[0]) && mreq_wdata == ~wa,
            "R1 payload", mreq_wdata, ~wa);
        chk(ireq_ready == 0 && dreq_ready == 0, "R2 busy", {ireq_ready, dreq_ready}, 0);
        mem_side(wa, mref);
        dst_i = wf;
        ed = mem_model(wa);
        chk(irsp_valid == dst_i && drsp_valid == !dst_i, "R4 route",
            {irsp_valid, drsp_valid}, {dst_i, !dst_i});
        chk((dst_i ? irsp_data : drsp_data) == ed && (dst_i ? irsp_fetch : drsp_fetch) == wf,
            "R4 data", dst_i ? irsp_data : drsp_data, ed);
        if (rref) begin
            chk(ireq_retry == 0 && dreq_retry == 0, "R8 no handover",
                {ireq_retry, dreq_retry}, 0);
            @(negedge clk); #1;
            chk((dst_i ? irsp_valid : drsp_valid) == 0, "R7 drop", 1, 0);
            if (dst_i) irsp_retry = 1; else drsp_retry = 1;
            @(negedge clk); irsp_retry = 0; drsp_retry = 0; #1;
            chk((dst_i ? irsp_valid : drsp_valid) == 1 && (dst_i ? irsp_data : drsp_data) == ed,
                "R7 resend", dst_i ? irsp_data : drsp_data, ed);
        end
        if (dst_i) irsp_ready = 1; else drsp_ready = 1;
        #1;
        chk(dreq_retry == owed_d && ireq_retry == 0, "R8 retry",
            {ireq_retry, dreq_retry}, {1'b0, owed_d});
        @(negedge clk); irsp_ready = 0; drsp_ready = 0; #1;
        chk(irsp_valid == 0 && drsp_valid == 0 && dreq_retry == 0, "R8 cleared",
            {irsp_valid, drsp_valid, dreq_retry}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        #1;
        chk(mreq_valid == 0 && irsp_valid == 0 && drsp_valid == 0 && mrsp_ready == 0,
            "R10 valids", {mreq_valid, irsp_valid, drsp_valid, mrsp_ready}, 0);
        chk(ireq_retry == 0 && dreq_retry == 0, "R10 retry", {ireq_retry, dreq_retry}, 0);
        @(negedge clk); rst = 0; #1;
        chk(ireq_ready == 1 && dreq_ready == 1, "R10 ready", {ireq_ready, dreq_ready}, 3);

        idx = 0;
        for (int who = 1; who < 4; who++)
            for (int f = 0; f < 4; f++)
                for (int m = 0; m < 2; m++)
                    for (int r = 0; r < 2; r++) begin
                        run_txn(idx, who[0], who[1], f[0], f[1], m[0], r[0]);
                        idx++;
                    end

        // R9: instruction buffer held, same-destination request refused
        @(negedge clk);
        ireq_valid = 1; ireq_fetch = 1; ireq_addr = 32'h3000; #1;
        chk(ireq_ready == 1, "R9 first", ireq_ready, 1);
        @(negedge clk); ireq_valid = 0;
        mem_side(32'h3000, 0);
        chk(irsp_valid == 1, "R4 inst", irsp_valid, 1);
        @(negedge clk); #1;
        chk(irsp_valid == 0, "R7 held", irsp_valid, 0);
        ireq_valid = 1; ireq_fetch = 1; ireq_addr = 32'h3100; #1;
        chk(ireq_ready == 0, "R9 refused", ireq_ready, 0);
        @(negedge clk); ireq_valid = 0;
        dreq_valid = 1; dreq_fetch = 0; dreq_addr = 32'h4000; #1;
        chk(dreq_ready == 1, "R9 other dest", dreq_ready, 1);
        @(negedge clk); dreq_valid = 0;
        mem_side(32'h4000, 0);
        chk(drsp_valid == 1 && drsp_data == mem_model(32'h4000), "R4 data port",
            drsp_data, mem_model(32'h4000));
        drsp_ready = 1; #1;
        chk(ireq_retry == 0, "R8 held buffer", ireq_retry, 0);
        @(negedge clk); drsp_ready = 0; irsp_retry = 1;
        @(negedge clk); irsp_retry = 0; #1;
        chk(irsp_valid == 1 && irsp_data == mem_model(32'h3000), "R7 resend",
            irsp_data, mem_model(32'h3000));
        irsp_ready = 1; #1;
        chk(ireq_retry == 1, "R8 paid", ireq_retry, 1);
        @(negedge clk); irsp_ready = 0; #1;
        chk(ireq_retry == 0, "R8 once", ireq_retry, 0);

        // R10: reset mid-flight clears owed retry and busy state
        @(negedge clk);
        ireq_valid = 1; ireq_fetch = 0; dreq_valid = 1; dreq_fetch = 0;
        @(negedge clk); ireq_valid = 0; dreq_valid = 0; rst = 1;
        @(negedge clk); rst = 0; #1;
        chk(mreq_valid == 0 && ireq_ready == 1, "R10 mid reset", {mreq_valid, ireq_ready}, 1);
        run_txn(99, 0, 1, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule